// File: doc/BRIEF.md
# Interrupt Control-State Register

This block is the memory-mapped 32-bit control and status word of a small processor's exception logic. One word brings together read-only status from the core and three software-writable pend flags. The status fields are the number of the exception now running, the number of the most urgent pending exception, a flag for a pending external configurable interrupt, and a flag that says whether a pending exception will be taken when debug halt ends. The pend flags cover three system exceptions: a periodic-timer exception, a context-switch exception and the non-maskable interrupt.

Software writes the word through a simple strobe-and-data port. The set and clear bits act only where a 1 is written. Each set bit reads back the live pending state. The pending flags also change through hardware: a timer-pend pulse sets the timer flag, and an exception-taken acknowledge from the core clears the flag of the source it accepted. The flags leave the block as registered outputs. Reads are combinational from the current flags and the status inputs.

Top module: `icsr_ctrl`

## Requirements
- R1: After a synchronous active-high reset, all three pend flags are 0, and bits 26, 28 and 31 of the read word are 0.
- R2: Read bits [8:0] equal the running-exception number input (0 means thread mode). Read bits [20:12] equal the most-urgent-pending number input (0 means none).
- R3: Read bit 22 follows the external-interrupt-pending input and read bit 23 follows the debug-preempt input. Reserved bits [11:9], 21, 24 and [30:29] always read 0.
- R4: A write with bit 28 = 1 pends the context-switch exception at the next clock edge, and a write with bit 27 = 1 unpends it. Bit 28 reads the pending state. A write with 0 in bits 27 and 28 leaves the flag unchanged.
- R5: A write with bit 26 = 1 pends the timer exception, and a write with bit 25 = 1 unpends it, whether software or hardware set it. Bit 26 reads the pending state.
- R6: A write with bit 31 = 1 pends the non-maskable interrupt, and bit 31 reads its state. No write bit clears it.
- R7: Clear bits 25 and 27 always read 0.
- R8: When a single write carries both the set bit and the clear bit of one exception, the clear takes effect and the flag is 0 after the edge.
- R9: An acknowledge input high at a clock edge clears the flag of that source at that edge, unless a set for the same source arrives at the same edge, in which case the flag stays 1.
- R10: A timer-pend pulse sets the timer flag at the next edge. It wins over a software timer clear at the same edge.
- R11: The outputs tick_pending, ctx_pending and nmi_pending equal read bits 26, 28 and 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe; the write takes effect at this edge |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read word |
| act_num | input | VEC_W | Number of the running exception |
| pend_num | input | VEC_W | Number of the most urgent pending exception |
| ext_irq_pend | input | 1 | External configurable interrupt pending |
| dbg_preempt | input | 1 | Pending exception will be taken on debug exit |
| tick_hw_set | input | 1 | Timer-pend pulse from the timer hardware |
| ack_tick | input | 1 | Core accepted the timer exception |
| ack_ctx | input | 1 | Core accepted the context-switch exception |
| ack_nmi | input | 1 | Core accepted the non-maskable interrupt |
| tick_pending | output | 1 | Timer exception pending |
| ctx_pending | output | 1 | Context-switch exception pending |
| nmi_pending | output | 1 | Non-maskable interrupt pending |

## Verification
Two collisions matter. A software write can fall in the same cycle as a hardware event, either a timer pulse or an acknowledge. A single write can also carry a set bit and a clear bit for one exception at once. Directed phases drive each pairing on one edge: a timer pulse with a timer clear, an acknowledge with a set, and set with clear for each exception. A random phase then mixes writes, pulses and acknowledges freely. The behavioural model in the bench applies the precedence rules (hardware set over software clear, clear over set, a new set over acknowledge), and the read word and the pending outputs are compared with it on every cycle.

// File: rtl/icsr_pkg.sv
package icsr_pkg;

  localparam int NUM_SRC  = 3;
  localparam int ACT_LSB  = 0;
  localparam int PEND_LSB = 12;
  localparam int EXT_BIT  = 22;
  localparam int DBG_BIT  = 23;
  localparam int TCLR_BIT = 25;
  localparam int TSET_BIT = 26;
  localparam int CCLR_BIT = 27;
  localparam int CSET_BIT = 28;
  localparam int NSET_BIT = 31;

  typedef enum logic [1:0] {
    SRC_TICK = 2'd0,
    SRC_CTX  = 2'd1,
    SRC_NMI  = 2'd2
  } src_e;

  typedef struct packed {
    logic set;
    logic clr;
  } sw_req_t;

  function automatic bit src_has_hw(int idx);
    return idx == int'(SRC_TICK);
  endfunction

  function automatic bit src_has_clr(int idx);
    return idx != int'(SRC_NMI);
  endfunction

endpackage

// File: rtl/icsr_wr_decode.sv
module icsr_wr_decode
  import icsr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                       wr_en,
  input  logic [DATA_W-1:0]          wr_data,
  output sw_req_t [NUM_SRC-1:0]      req
);

  always_comb begin
    req = '0;
    if (wr_en) begin
      req[SRC_TICK].set = wr_data[TSET_BIT];
      req[SRC_TICK].clr = wr_data[TCLR_BIT];
      req[SRC_CTX].set  = wr_data[CSET_BIT];
      req[SRC_CTX].clr  = wr_data[CCLR_BIT];
      req[SRC_NMI].set  = wr_data[NSET_BIT];
      req[SRC_NMI].clr  = 1'b0;
    end
  end

endmodule

// File: rtl/icsr_pend_bit.sv
module icsr_pend_bit #(
  parameter bit HW_SET  = 1'b0,
  parameter bit HAS_CLR = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic sw_set,
  input  logic sw_clr,
  input  logic hw_set,
  input  logic ack,
  output logic pend
);

  logic hw_eff;
  logic clr_eff;
  logic set_eff;
  logic nxt;

  generate
    if (HW_SET) begin : g_hw
      assign hw_eff = hw_set;
    end else begin : g_nohw
      assign hw_eff = 1'b0;
    end
    if (HAS_CLR) begin : g_clr
      // clear beats a software set, hardware set beats clear
      assign clr_eff = sw_clr & ~hw_eff;
      assign set_eff = sw_set & ~sw_clr;
    end else begin : g_noclr
      assign clr_eff = 1'b0;
      assign set_eff = sw_set;
    end
  endgenerate

  assign nxt = hw_eff | set_eff | (pend & ~clr_eff & ~ack);

  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= nxt;
  end

  // R8: set and clear together leave the flag low
  a_r8_clr_beats_set: assert property (@(posedge clk) disable iff (rst)
    (HAS_CLR && sw_set && sw_clr && !hw_eff) |=> !pend);

  // R10: hardware pend always lands
  a_r10_hw_set_lands: assert property (@(posedge clk) disable iff (rst)
    (HW_SET && hw_set) |=> pend);

  // R9: acknowledge without a fresh set drops the flag
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (ack && !sw_set && !hw_eff) |=> !pend);

  // R9: acknowledge with a fresh set keeps it
  a_r9_set_over_ack: assert property (@(posedge clk) disable iff (rst)
    (ack && sw_set && !(HAS_CLR && sw_clr)) |=> pend);

  // R4: nothing requested, nothing changes
  a_r4_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (!sw_set && !sw_clr && !hw_eff && !ack) |=> $stable(pend));

endmodule

// File: rtl/icsr_status_pack.sv
module icsr_status_pack
  import icsr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int VEC_W  = 9
) (
  input  logic [VEC_W-1:0]   act_num,
  input  logic [VEC_W-1:0]   pend_num,
  input  logic               ext_irq_pend,
  input  logic               dbg_preempt,
  input  logic [NUM_SRC-1:0] flags,
  output logic [DATA_W-1:0]  word
);

  always_comb begin
    word = '0;
    word[ACT_LSB  +: VEC_W] = act_num;
    word[PEND_LSB +: VEC_W] = pend_num;
    word[EXT_BIT]  = ext_irq_pend;
    word[DBG_BIT]  = dbg_preempt;
    word[TSET_BIT] = flags[SRC_TICK];
    word[CSET_BIT] = flags[SRC_CTX];
    word[NSET_BIT] = flags[SRC_NMI];
  end

endmodule

// File: rtl/icsr_ctrl.sv
module icsr_ctrl
  import icsr_pkg::*;
#(
  parameter int VEC_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data,
  input  logic [VEC_W-1:0] act_num,
  input  logic [VEC_W-1:0] pend_num,
  input  logic             ext_irq_pend,
  input  logic             dbg_preempt,
  input  logic             tick_hw_set,
  input  logic             ack_tick,
  input  logic             ack_ctx,
  input  logic             ack_nmi,
  output logic             tick_pending,
  output logic             ctx_pending,
  output logic             nmi_pending
);

  localparam int DATA_W = 32;

  sw_req_t [NUM_SRC-1:0] req;
  logic    [NUM_SRC-1:0] hw_vec;
  logic    [NUM_SRC-1:0] ack_vec;
  logic    [NUM_SRC-1:0] flags;

  assign hw_vec  = {1'b0, 1'b0, tick_hw_set};
  assign ack_vec = {ack_nmi, ack_ctx, ack_tick};

  icsr_wr_decode #(.DATA_W(DATA_W)) u_dec (
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .req     (req)
  );

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      icsr_pend_bit #(
        .HW_SET  (src_has_hw(s)),
        .HAS_CLR (src_has_clr(s))
      ) u_bit (
        .clk    (clk),
        .rst    (rst),
        .sw_set (req[s].set),
        .sw_clr (req[s].clr),
        .hw_set (hw_vec[s]),
        .ack    (ack_vec[s]),
        .pend   (flags[s])
      );
    end
  endgenerate

  icsr_status_pack #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_pack (
    .act_num      (act_num),
    .pend_num     (pend_num),
    .ext_irq_pend (ext_irq_pend),
    .dbg_preempt  (dbg_preempt),
    .flags        (flags),
    .word         (rd_data)
  );

  assign tick_pending = flags[SRC_TICK];
  assign ctx_pending  = flags[SRC_CTX];
  assign nmi_pending  = flags[SRC_NMI];

  // R1: reset empties every flag
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!tick_pending && !ctx_pending && !nmi_pending));

  // R6: nothing but an acknowledge removes a pending NMI
  a_r6_nmi_sticky: assert property (@(posedge clk) disable iff (rst)
    (nmi_pending && !ack_nmi) |=> nmi_pending);

  // R7 / R3: clear and reserved positions read low
  always_comb begin
    a_r7_clr_bits_zero: assert (rd_data[TCLR_BIT] == 1'b0 && rd_data[CCLR_BIT] == 1'b0);
    a_r3_reserved_zero: assert (rd_data[11:9] == 3'b0 && rd_data[21] == 1'b0 &&
                                rd_data[24] == 1'b0 && rd_data[30:29] == 2'b0);
    // R11: outputs agree with the read word
    a_r11_out_match: assert (rd_data[TSET_BIT] == tick_pending &&
                             rd_data[CSET_BIT] == ctx_pending &&
                             rd_data[NSET_BIT] == nmi_pending);
  end

endmodule

// File: tb/sim_icsr_ctrl.sv
`timescale 1ns/1ps
module sim_icsr_ctrl;

  localparam int VW = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [VW-1:0] act_num = '0;
  logic [VW-1:0] pend_num = '0;
  logic ext_irq_pend = 1'b0;
  logic dbg_preempt = 1'b0;
  logic tick_hw_set = 1'b0;
  logic ack_tick = 1'b0, ack_ctx = 1'b0, ack_nmi = 1'b0;
  logic tick_pending, ctx_pending, nmi_pending;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // model state
  bit m_tick = 0, m_ctx = 0, m_nmi = 0;

  always #2.5 clk = ~clk;

  icsr_ctrl #(.VEC_W(VW)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .act_num(act_num), .pend_num(pend_num), .ext_irq_pend(ext_irq_pend),
    .dbg_preempt(dbg_preempt), .tick_hw_set(tick_hw_set),
    .ack_tick(ack_tick), .ack_ctx(ack_ctx), .ack_nmi(ack_nmi),
    .tick_pending(tick_pending), .ctx_pending(ctx_pending), .nmi_pending(nmi_pending)
  );

  // behavioural reference: precedence rules from the requirements
  always @(posedge clk) begin
    bit ts, tc, cs, cc, ns;
    ts = wr_en && wr_data[26]; tc = wr_en && wr_data[25];
    cs = wr_en && wr_data[28]; cc = wr_en && wr_data[27];
    ns = wr_en && wr_data[31];
    if (rst) begin
      m_tick <= 0; m_ctx <= 0; m_nmi <= 0;
    end else begin
      if (tick_hw_set)      m_tick <= 1;          // R10
      else if (tc)          m_tick <= 0;          // R5, R8
      else if (ts)          m_tick <= 1;
      else if (ack_tick)    m_tick <= 0;          // R9
      if (cc)               m_ctx <= 0;           // R4, R8
      else if (cs)          m_ctx <= 1;
      else if (ack_ctx)     m_ctx <= 0;
      if (ns)               m_nmi <= 1;           // R6
      else if (ack_nmi)     m_nmi <= 0;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // compare every cycle away from the edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R2 active field",  32'(rd_data[8:0]),   32'(act_num));
      check("R2 pending field", 32'(rd_data[20:12]), 32'(pend_num));
      check("R3 status flags",  32'({rd_data[23], rd_data[22]}), 32'({dbg_preempt, ext_irq_pend}));
      check("R3 reserved bits", 32'({rd_data[11:9], rd_data[21], rd_data[24], rd_data[30:29]}), 32'h0);
      check("R4 ctx bit 28",    32'(rd_data[28]), 32'(m_ctx));
      check("R5 tick bit 26",   32'(rd_data[26]), 32'(m_tick));
      check("R6 nmi bit 31",    32'(rd_data[31]), 32'(m_nmi));
      check("R7 clear bits",    32'({rd_data[27], rd_data[25]}), 32'h0);
      check("R11 outputs",      32'({nmi_pending, ctx_pending, tick_pending}),
                                32'({rd_data[31], rd_data[28], rd_data[26]}));
    end
  end

  task automatic step(input logic we, input logic [31:0] d, input logic hw,
                      input logic at, input logic ac, input logic an);
    wr_en = we; wr_data = d; tick_hw_set = hw;
    ack_tick = at; ack_ctx = ac; ack_nmi = an;
    @(negedge clk);
    wr_en = 0; wr_data = '0; tick_hw_set = 0; ack_tick = 0; ack_ctx = 0; ack_nmi = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: flags low after reset
    check("R1 reset flags", {29'b0, nmi_pending, ctx_pending, tick_pending}, 32'h0);
    act_num = 9'h1A5; pend_num = 9'h0F3; ext_irq_pend = 1; dbg_preempt = 1;
    @(negedge clk);
    step(1, 32'h1000_0000, 0, 0, 0, 0);            // R4 set ctx
    check("R4 ctx set", 32'(ctx_pending), 32'h1);
    step(1, 32'h0000_0000, 0, 0, 0, 0);            // R4 zero write
    check("R4 zero write no effect", 32'(ctx_pending), 32'h1);
    step(1, 32'h0800_0000, 0, 0, 0, 0);
    check("R4 ctx clear", 32'(ctx_pending), 32'h0);
    step(0, 0, 1, 0, 0, 0);                          // R10 hw pulse
    check("R10 hw set", 32'(tick_pending), 32'h1);
    step(1, 32'h0200_0000, 0, 0, 0, 0);            // R5 sw clears hw-set
    check("R5 clear hw-set tick", 32'(tick_pending), 32'h0);
    step(1, 32'h0200_0000, 1, 0, 0, 0);            // R10 hw beats sw clear
    check("R10 hw wins over clear", 32'(tick_pending), 32'h1);
    step(1, 32'h1800_0000, 0, 0, 0, 0);            // R8 ctx set+clr
    check("R8 ctx clear wins", 32'(ctx_pending), 32'h0);
    step(1, 32'h0600_0000, 0, 0, 0, 0);            // R8 tick set+clr, was 1
    check("R8 tick clear wins", 32'(tick_pending), 32'h0);
    step(1, 32'h8000_0000, 0, 0, 0, 0);
    check("R6 nmi set", 32'(nmi_pending), 32'h1);
    step(1, 32'h7FFF_FFFF, 0, 0, 0, 0);            // R6 no clear bit for nmi
    check("R6 nmi survives writes", 32'(nmi_pending), 32'h1);
    step(0, 0, 0, 0, 0, 1);
    check("R9 nmi ack clears", 32'(nmi_pending), 32'h0);
    step(1, 32'h1000_0000, 0, 0, 1, 0);            // R9 set with ack
    check("R9 set beats ack", 32'(ctx_pending), 32'h1);
    step(0, 0, 0, 0, 1, 0);
    check("R9 ctx ack clears", 32'(ctx_pending), 32'h0);
    step(0, 0, 1, 1, 0, 0);
    check("R9 hw set beats tick ack", 32'(tick_pending), 32'h1);
    // random mixing of all events
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d;
      d = $urandom;
      act_num = VW'($urandom); pend_num = VW'($urandom);
      ext_irq_pend = 1'($urandom); dbg_preempt = 1'($urandom);
      step(1'($urandom), d, ($urandom % 4) == 0, ($urandom % 3) == 0,
           ($urandom % 3) == 0, ($urandom % 5) == 0);
    end
    rst = 1;
    @(negedge clk);
    rst = 0;
    check("R1 flags after late reset", {29'b0, nmi_pending, ctx_pending, tick_pending}, 32'h0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule